// File: doc/BRIEF.md
# Bit-Sliced Feistel Round Datapath

This block computes one round of a scalable Feistel cipher in pure combinational logic. It takes the left and right halves of the block, a round key as wide as one half, and a direction bit. It returns the next pair of halves. The block defaults to a 48-bit block built from 8-bit words, so each half holds three words. Both the block width and the word width are parameters. Elaboration stops with an error unless the block width is a multiple of six words.

The round function takes the right half and passes it through four steps in turn:

1. It adds the round key word by word.
2. It applies a nonlinear layer that works bit-sliced across each triple of words.
3. It rotates the bits inside the outer words of each triple.
4. It merges the result with the left half.

In the forward direction, the left half is rotated by whole words before the XOR. In the reverse direction, the inverse word rotation is applied after the XOR. This lets one round undo the other. A surrounding sequencer supplies the round keys, counts the rounds and holds the state between rounds.

Top module: `feistel_round_dp`

## Requirements
- R1: In both directions, `left_out` equals `right_in`.
- R2: Key mixing adds each b-bit word of `right_in` to the same word of `rkey` modulo 2^b. No carry crosses from one word into the next.
- R3: For each word triple (3i, 3i+1, 3i+2) and each bit position, the nonlinear layer updates the bits in sequence, with each step using the values already updated:
  1. word 3i is XORed with (word 3i+2 AND word 3i+1);
  2. word 3i+1 is XORed with (word 3i+2 AND the new word 3i);
  3. word 3i+2 is XORed with (the new word 3i OR the new word 3i+1).
- R4: After the nonlinear layer, word 3i of each triple is rotated right by one bit and word 3i+2 is rotated left by one bit. Word 3i+1 is left unchanged.
- R5: With `dec_mode`=0 (encrypt), `right_out` equals the word-rotated `left_in` XOR the round function output. The word rotation moves word j to position j+1, and the top word to position 0.
- R6: With `dec_mode`=1 (decrypt), `right_out` equals the inverse word rotation of (`left_in` XOR the round function output). The inverse rotation moves word j+1 to position j, and word 0 to the top position.
- R7: Word 0 of every half and of the key occupies the least significant b bits.
- R8: Take an encrypt round on (L, R, K) that gives (L', R'). A decrypt round on left=R', right=L', key K then gives left=R and right=L.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| left_in | input | BLK_W/2 | Current left half |
| right_in | input | BLK_W/2 | Current right half |
| rkey | input | BLK_W/2 | Round key |
| dec_mode | input | 1 | 0 = encrypt round, 1 = decrypt round |
| left_out | output | BLK_W/2 | Next left half |
| right_out | output | BLK_W/2 | Next right half |

## Verification
The bench targets the following corner cases:

- **Carry isolation.** A word of 0xFF plus a key word of 1 must wrap to zero. A design that leaks the carry sets the next word, and the nonlinear layer then produces a nonzero output where zero is expected.
- **Word-rotation direction.** Distinct word values in the left half expose a design that rotates the wrong way, or that places the inverse rotation before the XOR.
- **Nonlinear layer with a single set bit.** This shows whether each step uses the freshly updated words, and whether each outer word rotates in the correct direction.
- **Random round-trips.** A decrypt round on the swapped halves must restore the original halves exactly.

// File: rtl/sea_round_pkg.sv
package sea_round_pkg;
  typedef enum logic {
    DIR_ENC = 1'b0,
    DIR_DEC = 1'b1
  } round_dir_e;
endpackage

// File: rtl/key_mix.sv
// Word-wise modular addition: carries stay inside each word.
module key_mix #(
  parameter int HALF_W = 24,
  parameter int WORD_W = 8
) (
  input  logic [HALF_W-1:0] a_in,
  input  logic [HALF_W-1:0] b_in,
  output logic [HALF_W-1:0] sum_out
);
  localparam int NWORDS = HALF_W / WORD_W;

  function automatic logic [WORD_W-1:0] add_word(input logic [WORD_W-1:0] x,
                                                 input logic [WORD_W-1:0] y);
    return x + y;
  endfunction

  for (genvar i = 0; i < NWORDS; i++) begin : g_word
    assign sum_out[i*WORD_W +: WORD_W] = add_word(a_in[i*WORD_W +: WORD_W],
                                                  b_in[i*WORD_W +: WORD_W]);
  end
endmodule

// File: rtl/slice_sbox.sv
// Bit-sliced nonlinear layer on each triple of words, applied in sequence.
module slice_sbox #(
  parameter int HALF_W = 24,
  parameter int WORD_W = 8
) (
  input  logic [HALF_W-1:0] d_in,
  output logic [HALF_W-1:0] d_out
);
  localparam int NTRIP = HALF_W / (3 * WORD_W);

  for (genvar t = 0; t < NTRIP; t++) begin : g_trip
    localparam int B0 = (3*t) * WORD_W;
    localparam int B1 = (3*t + 1) * WORD_W;
    localparam int B2 = (3*t + 2) * WORD_W;
    logic [WORD_W-1:0] w0, w1, w2, u0, u1, u2;
    assign w0 = d_in[B0 +: WORD_W];
    assign w1 = d_in[B1 +: WORD_W];
    assign w2 = d_in[B2 +: WORD_W];
    assign u0 = w0 ^ (w2 & w1);
    assign u1 = w1 ^ (w2 & u0);
    assign u2 = w2 ^ (u0 | u1);
    assign d_out[B0 +: WORD_W] = u0;
    assign d_out[B1 +: WORD_W] = u1;
    assign d_out[B2 +: WORD_W] = u2;
  end
endmodule

// File: rtl/bit_twist.sv
// Per-word bit rotation: outer words of each triple turn in opposite senses.
module bit_twist #(
  parameter int HALF_W = 24,
  parameter int WORD_W = 8
) (
  input  logic [HALF_W-1:0] d_in,
  output logic [HALF_W-1:0] d_out
);
  localparam int NTRIP = HALF_W / (3 * WORD_W);

  function automatic logic [WORD_W-1:0] rot_r1(input logic [WORD_W-1:0] x);
    return {x[0], x[WORD_W-1:1]};
  endfunction

  function automatic logic [WORD_W-1:0] rot_l1(input logic [WORD_W-1:0] x);
    return {x[WORD_W-2:0], x[WORD_W-1]};
  endfunction

  for (genvar t = 0; t < NTRIP; t++) begin : g_trip
    localparam int B0 = (3*t) * WORD_W;
    localparam int B1 = (3*t + 1) * WORD_W;
    localparam int B2 = (3*t + 2) * WORD_W;
    assign d_out[B0 +: WORD_W] = rot_r1(d_in[B0 +: WORD_W]);
    assign d_out[B1 +: WORD_W] = d_in[B1 +: WORD_W];
    assign d_out[B2 +: WORD_W] = rot_l1(d_in[B2 +: WORD_W]);
  end
endmodule

// File: rtl/word_spin.sv
// Whole-word rotation; FWD=1 moves word j to j+1, FWD=0 the reverse.
module word_spin #(
  parameter int HALF_W = 24,
  parameter int WORD_W = 8,
  parameter bit FWD    = 1'b1
) (
  input  logic [HALF_W-1:0] d_in,
  output logic [HALF_W-1:0] d_out
);
  localparam int NWORDS = HALF_W / WORD_W;

  for (genvar i = 0; i < NWORDS; i++) begin : g_word
    if (FWD) begin : g_fwd
      localparam int SRC = (i + NWORDS - 1) % NWORDS;
      assign d_out[i*WORD_W +: WORD_W] = d_in[SRC*WORD_W +: WORD_W];
    end else begin : g_inv
      localparam int SRC = (i + 1) % NWORDS;
      assign d_out[i*WORD_W +: WORD_W] = d_in[SRC*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/feistel_round_dp.sv
module feistel_round_dp
  import sea_round_pkg::*;
#(
  parameter int BLK_W  = 48,
  parameter int WORD_W = 8
) (
  input  logic [BLK_W/2-1:0] left_in,
  input  logic [BLK_W/2-1:0] right_in,
  input  logic [BLK_W/2-1:0] rkey,
  input  logic               dec_mode,
  output logic [BLK_W/2-1:0] left_out,
  output logic [BLK_W/2-1:0] right_out
);
  localparam int HALF_W = BLK_W / 2;

  if (BLK_W % (6 * WORD_W) != 0) begin : g_bad_size
    $error("feistel_round_dp: BLK_W must be a multiple of 6*WORD_W");
  end

  round_dir_e dir;
  assign dir = round_dir_e'(dec_mode);

  // Named internal stages, visible to the bound checker.
  logic [HALF_W-1:0] mix_w;
  logic [HALF_W-1:0] sub_w;
  logic [HALF_W-1:0] twist_w;
  logic [HALF_W-1:0] spin_f_w;
  logic [HALF_W-1:0] pre_inv_w;
  logic [HALF_W-1:0] spin_i_w;

  key_mix #(.HALF_W(HALF_W), .WORD_W(WORD_W)) u_mix (
    .a_in(right_in), .b_in(rkey), .sum_out(mix_w));

  slice_sbox #(.HALF_W(HALF_W), .WORD_W(WORD_W)) u_sub (
    .d_in(mix_w), .d_out(sub_w));

  bit_twist #(.HALF_W(HALF_W), .WORD_W(WORD_W)) u_twist (
    .d_in(sub_w), .d_out(twist_w));

  word_spin #(.HALF_W(HALF_W), .WORD_W(WORD_W), .FWD(1'b1)) u_spin_f (
    .d_in(left_in), .d_out(spin_f_w));

  assign pre_inv_w = left_in ^ twist_w;

  word_spin #(.HALF_W(HALF_W), .WORD_W(WORD_W), .FWD(1'b0)) u_spin_i (
    .d_in(pre_inv_w), .d_out(spin_i_w));

  assign left_out  = right_in;
  assign right_out = (dir == DIR_DEC) ? spin_i_w : (spin_f_w ^ twist_w);
endmodule

// File: rtl/feistel_round_chk.sv
module feistel_round_chk #(
  parameter int HALF_W = 24,
  parameter int WORD_W = 8
) (
  input logic [HALF_W-1:0] left_in,
  input logic [HALF_W-1:0] right_in,
  input logic [HALF_W-1:0] rkey,
  input logic [HALF_W-1:0] left_out,
  input logic [HALF_W-1:0] mix_w,
  input logic [HALF_W-1:0] sub_w,
  input logic [HALF_W-1:0] twist_w,
  input logic [HALF_W-1:0] spin_f_w,
  input logic [HALF_W-1:0] pre_inv_w,
  input logic [HALF_W-1:0] spin_i_w
);
  localparam int NWORDS = HALF_W / WORD_W;

  always_comb begin
    a_r1_left_pass: assert (left_out == right_in)
      else $error("R1: left_out differs from right_in");
    // R3: an all-zero input to the nonlinear layer must stay zero
    a_r3_zero_fixed: assert (mix_w != '0 || sub_w == '0)
      else $error("R3: zero input not fixed");
    a_r4_rot_weight: assert ($countones(sub_w) == $countones(twist_w))
      else $error("R4: bit rotation changed weight");
    a_r5_spin_weight: assert ($countones(left_in) == $countones(spin_f_w))
      else $error("R5: forward word rotation changed weight");
    a_r6_spin_weight: assert ($countones(pre_inv_w) == $countones(spin_i_w))
      else $error("R6: inverse word rotation changed weight");
    for (int i = 0; i < NWORDS; i++) begin
      // R2: the lowest bit of each word gets no carry from the word below
      a_r2_no_carry_in: assert (mix_w[i*WORD_W] == (right_in[i*WORD_W] ^ rkey[i*WORD_W]))
        else $error("R2: carry entered word %0d", i);
    end
  end
endmodule

bind feistel_round_dp feistel_round_chk #(.HALF_W(HALF_W), .WORD_W(WORD_W)) u_chk (
  .left_in(left_in), .right_in(right_in), .rkey(rkey), .left_out(left_out),
  .mix_w(mix_w), .sub_w(sub_w), .twist_w(twist_w), .spin_f_w(spin_f_w),
  .pre_inv_w(pre_inv_w), .spin_i_w(spin_i_w));

// File: tb/sim_feistel_round_dp.sv
module sim_feistel_round_dp;
  localparam int BW = 48;
  localparam int WW = 8;
  localparam int HW = BW / 2;
  localparam int NW = HW / WW;

  typedef struct {
    logic [HW-1:0] l;
    logic [HW-1:0] r;
    string         tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [HW-1:0] left_in = '0, right_in = '0, rkey = '0;
  logic          dec_mode = 1'b0;
  logic [HW-1:0] left_out, right_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  exp_t sb[$];

  feistel_round_dp #(.BLK_W(BW), .WORD_W(WW)) u0 (
    .left_in(left_in), .right_in(right_in), .rkey(rkey), .dec_mode(dec_mode),
    .left_out(left_out), .right_out(right_out));

  // Independent model, bit-by-bit over word arrays.
  function automatic logic [HW-1:0] m_f(input logic [HW-1:0] r, input logic [HW-1:0] k);
    logic [WW-1:0] w [NW];
    logic [HW-1:0] res;
    for (int j = 0; j < NW; j++) w[j] = WW'(r[j*WW +: WW] + k[j*WW +: WW]);
    for (int t = 0; t < NW / 3; t++) begin
      for (int b = 0; b < WW; b++) begin
        logic a, m, c;
        a = w[3*t][b]; m = w[3*t+1][b]; c = w[3*t+2][b];
        a = a ^ (c & m);
        m = m ^ (c & a);
        c = c ^ (a | m);
        w[3*t][b] = a; w[3*t+1][b] = m; w[3*t+2][b] = c;
      end
    end
    for (int t = 0; t < NW / 3; t++) begin
      logic [WW-1:0] x0, x2;
      x0 = w[3*t]; x2 = w[3*t+2];
      for (int b = 0; b < WW; b++) begin
        w[3*t][b]   = x0[(b + 1) % WW];
        w[3*t+2][b] = x2[(b + WW - 1) % WW];
      end
    end
    for (int j = 0; j < NW; j++) res[j*WW +: WW] = w[j];
    return res;
  endfunction

  function automatic logic [HW-1:0] m_rot(input logic [HW-1:0] x, input bit fwd);
    logic [HW-1:0] y;
    for (int j = 0; j < NW; j++) begin
      if (fwd) y[((j + 1) % NW)*WW +: WW] = x[j*WW +: WW];
      else     y[j*WW +: WW] = x[((j + 1) % NW)*WW +: WW];
    end
    return y;
  endfunction

  // Driver: apply inputs after a rising edge, queue the expected result.
  task automatic drive(input logic [HW-1:0] l, input logic [HW-1:0] r,
                       input logic [HW-1:0] k, input logic d,
                       input logic [HW-1:0] el, input logic [HW-1:0] er, input string tag);
    exp_t e;
    @(posedge clk);
    left_in = l; right_in = r; rkey = k; dec_mode = d;
    e.l = el; e.r = er; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic drive_model(input logic [HW-1:0] l, input logic [HW-1:0] r,
                             input logic [HW-1:0] k, input logic d, input string tag);
    logic [HW-1:0] er;
    if (d) er = m_rot(l ^ m_f(r, k), 1'b0);
    else   er = m_rot(l, 1'b1) ^ m_f(r, k);
    drive(l, r, k, d, r, er, tag);
  endtask

  // Monitor: compare on the falling edge.
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (left_out !== e.l || right_out !== e.r) begin
        failures++;
        $display("FAIL %s: got l=%h r=%h expected l=%h r=%h",
                 e.tag, left_out, right_out, e.l, e.r);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // All-zero inputs in both directions (R1, R3)
    drive('0, '0, '0, 1'b0, '0, '0, "R1 R3 zero enc");
    drive('0, '0, '0, 1'b1, '0, '0, "R1 R3 zero dec");
    // R2: 0xFF+1 wraps inside word 0 and must not touch word 1
    drive('0, 24'h0000FF, 24'h000001, 1'b0, 24'h0000FF, '0, "R2 carry isolation enc");
    drive('0, 24'h00FFFF, 24'h000101, 1'b1, 24'h00FFFF, '0, "R2 carry isolation dec");
    // R5 R7: forward word rotation, word 0 in the LSBs
    drive(24'h030201, '0, '0, 1'b0, '0, 24'h020103, "R5 R7 word rotation");
    // R6: inverse word rotation
    drive(24'h030201, '0, '0, 1'b1, '0, 24'h010302, "R6 inverse word rotation");
    // R3 R4: a single set bit in word 0 gives words (80,00,02) in encrypt
    drive('0, 24'h000001, '0, 1'b0, 24'h000001, 24'h020080, "R3 R4 single bit");
    // R6: decrypt XOR happens before the inverse rotation
    drive(24'h000080, 24'h000001, '0, 1'b1, 24'h000001, 24'h000200, "R6 xor before rotate");
    // R3 R4: pattern with all three words active
    drive_model('0, 24'h0F3355, 24'h010203, 1'b0, "R3 R4 mixed triple");
    for (int n = 0; n < 40; n++) begin
      logic [HW-1:0] l, r, k, er;
      l = HW'($urandom); r = HW'($urandom); k = HW'($urandom);
      drive_model(l, r, k, 1'b0, "R5 random encrypt");
      drive_model(l, r, k, 1'b1, "R6 random decrypt");
      // R8: decrypt on swapped encrypt output restores the halves
      er = m_rot(l, 1'b1) ^ m_f(r, k);
      drive(er, r, k, 1'b1, r, l, "R8 round trip");
    end
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got hang expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule